// File: doc/BRIEF.md
# Bit-Serial Packet CRC Generator with Selectable Polynomial

This block sits in a transmit packet path. It takes a packet one byte at a time and turns each byte into a serial bit stream. It keeps a 16-bit CRC over the bits it sends. After the final byte it appends the two CRC bytes to the same stream. Each packet opens with a one-cycle start pulse. Every byte arrives with a valid strobe, a tag that marks it as payload or as header/length, and a last-byte marker. The block raises `byteReady` whenever it can take the next byte.

A small control register sets the behaviour. It selects one of four 16-bit polynomials, and it can turn CRC generation on or off. It can limit CRC coverage to payload bytes only, and it picks whether each byte goes out least- or most-significant bit first. A separate enable turns packet handling on or off. With packet handling off, bytes are serialized untouched and no CRC follows. The register is copied into a working set only when a packet starts. A write made during a packet therefore takes effect only for the next one.

The CRC register is preset to all ones at the start of a packet. It is updated one bit per cycle, in the order the bits leave the block. No final inversion is applied. The running value is visible on `crcValue` at all times.

Top module: `pkt_crc_gen`

## Requirements
- R1: After reset the control register holds 8'b1000_1101. Its fields are bit 6 = LSB-first, bit 5 = payload-only coverage, bit 3 = packet handling enable, bit 2 = CRC enable, bits 1:0 = polynomial code, and bits 7 and 4 have no effect. Also after reset, `byteReady` and `txValid` are low and `crcValue` is 16'hFFFF.
- R2: The polynomial codes are 00 = 16'h1021, 01 = 16'h8005, 10 = 16'h3D65, and 11 = the `ALT_POLY` parameter (default 16'h8BB7). Code 00 over the ASCII bytes "123456789" gives 16'h29B1, and code 01 over the same bytes gives 16'hAEE7.
- R3: A start pulse while idle sets `crcValue` to 16'hFFFF on the next cycle. The CRC then advances one bit per transmitted covered bit, in transmission order, using a non-reflected shift with no final XOR. `crcValue` holds steady in any cycle that sends no bit.
- R4: When payload-only coverage is set, bytes with `byteIsData`=0 are serialized but do not change the CRC. When it is clear, every byte is covered.
- R5: With LSB-first set, each byte (CRC bytes included) is sent bit 0 first. With it clear, each byte is sent bit 7 first.
- R6: With both packet handling and CRC enabled, 16 CRC bits follow the last byte, high byte first, with `txIsCrc` high. `txLast` marks the final CRC bit.
- R7: If CRC enable or packet handling enable is clear, no CRC bits are sent, `txLast` marks the last data bit, and `crcValue` stays 16'hFFFF.
- R8: A control write during a packet does not change that packet's stream or CRC. The next packet uses the written value.
- R9: A start pulse while a packet is in progress is ignored.
- R10: A byte accepted at a clock edge (`byteValid` and `byteReady`) puts its first bit on `txBit` with `txValid` high in the following cycle, and `byteReady` drops for the 8 bit cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Control register write strobe |
| cfgData | input | 8 | Control register write value |
| sopPulse | input | 1 | One-cycle start-of-packet pulse |
| byteValid | input | 1 | Input byte valid |
| byteData | input | 8 | Input byte |
| byteIsData | input | 1 | 1 = payload byte, 0 = header/length byte |
| lastByte | input | 1 | Marks the final byte of the packet |
| byteReady | output | 1 | Block can accept a byte this cycle |
| txValid | output | 1 | `txBit` carries a transmitted bit |
| txBit | output | 1 | Serial output bit |
| txIsCrc | output | 1 | Current bit belongs to the appended CRC |
| txLast | output | 1 | Current bit is the final bit of the packet |
| crcValue | output | 16 | Running CRC register |

## Verification
A byte accepted at an edge shows its first bit in the next cycle and its eighth bit seven cycles after that. Each covered bit reaches `crcValue` at the edge that ends its cycle. The CRC bits start two cycles after the last data bit, because one gap cycle loads the shifter. `crcValue` reads 16'hFFFF one cycle after a start pulse. The bench drives inputs and samples outputs at falling edges. It records every bit seen with `txValid` high, and compares the whole stream and the final `crcValue` with a bench model once `txLast` has been seen. The acceptance check is made at the first falling edge after the accepting edge.

// File: rtl/pkt_crc_pkg.sv
package pkt_crc_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam int CFG_W  = 8;
  localparam int CNT_W  = $clog2(CRC_W);

  // control field positions (the write value is decoded here)
  localparam int POS_LSB   = 6;
  localparam int POS_DONLY = 5;
  localparam int POS_PKT   = 3;
  localparam int POS_CRC   = 2;

  typedef enum logic [1:0] {
    POLY_CCITT = 2'b00,
    POLY_IBM   = 2'b01,
    POLY_IEC   = 2'b10,
    POLY_ALT   = 2'b11
  } polySel_e;

  typedef struct packed {
    logic     lsbFirst;
    logic     dataOnly;
    logic     pktEn;
    logic     crcEn;
    polySel_e polySel;
  } cfgFields_t;

  typedef struct packed {
    logic preset;
    logic loadByte;
    logic loadCrc;
    logic shift;
    logic update;
  } dpStrobes_t;

  function automatic cfgFields_t decodeCfg(input logic [CFG_W-1:0] raw);
    cfgFields_t f;
    f.lsbFirst = raw[POS_LSB];
    f.dataOnly = raw[POS_DONLY];
    f.pktEn    = raw[POS_PKT];
    f.crcEn    = raw[POS_CRC];
    f.polySel  = polySel_e'(raw[1:0]);
    return f;
  endfunction

  function automatic logic [CRC_W-1:0] polyFor(input polySel_e sel,
                                               input logic [CRC_W-1:0] altPoly);
    case (sel)
      POLY_CCITT: return 16'h1021;
      POLY_IBM:   return 16'h8005;
      POLY_IEC:   return 16'h3D65;
      default:    return altPoly;
    endcase
  endfunction
endpackage

// File: rtl/pkt_crc_ctrl.sv
module pkt_crc_ctrl
  import pkt_crc_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = 8'b1000_1101
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             sopPulse,
  input  logic             byteValid,
  input  logic             byteIsData,
  input  logic             lastByte,
  output logic             byteReady,
  output dpStrobes_t       strobes,
  output cfgFields_t       actCfg,
  output logic             txValid,
  output logic             txIsCrc,
  output logic             txLast,
  output logic             busy
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_BYTE, ST_CRCLD, ST_CRC
  } state_e;

  state_e           state;
  logic [CFG_W-1:0] cfgReg;
  logic             covered;
  logic             lastFlag;
  logic [CNT_W-1:0] bitCnt;
  logic             crcOn;
  logic             cntZero;

  assign crcOn   = actCfg.pktEn && actCfg.crcEn;
  assign cntZero = (bitCnt == '0);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobes   = '0;
    byteReady = 1'b0;
    txValid   = 1'b0;
    txIsCrc   = 1'b0;
    txLast    = 1'b0;
    case (state)
      ST_IDLE:  strobes.preset = sopPulse;
      ST_WAIT: begin
        byteReady        = 1'b1;
        strobes.loadByte = byteValid;
      end
      ST_BYTE: begin
        strobes.shift  = 1'b1;
        strobes.update = covered && crcOn;
        txValid        = 1'b1;
        txLast         = cntZero && lastFlag && !crcOn;
      end
      ST_CRCLD: strobes.loadCrc = 1'b1;
      ST_CRC: begin
        strobes.shift = 1'b1;
        txValid       = 1'b1;
        txIsCrc       = 1'b1;
        txLast        = cntZero;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cfgReg   <= RESET_CFG;
      actCfg   <= decodeCfg(RESET_CFG);
      covered  <= 1'b0;
      lastFlag <= 1'b0;
      bitCnt   <= '0;
    end else begin
      if (cfgWe) cfgReg <= cfgData;
      case (state)
        ST_IDLE: if (sopPulse) begin
          actCfg <= decodeCfg(cfgReg);
          state  <= ST_WAIT;
        end
        ST_WAIT: if (byteValid) begin
          covered  <= !actCfg.dataOnly || byteIsData;
          lastFlag <= lastByte;
          bitCnt   <= CNT_W'(BYTE_W - 1);
          state    <= ST_BYTE;
        end
        ST_BYTE: begin
          if (cntZero) begin
            if (!lastFlag)  state <= ST_WAIT;
            else if (crcOn) state <= ST_CRCLD;
            else            state <= ST_IDLE;
          end else begin
            bitCnt <= bitCnt - 1'b1;
          end
        end
        ST_CRCLD: begin
          bitCnt <= CNT_W'(CRC_W - 1);
          state  <= ST_CRC;
        end
        ST_CRC: begin
          if (cntZero) state <= ST_IDLE;
          else         bitCnt <= bitCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_crc_dp.sv
module pkt_crc_dp
  import pkt_crc_pkg::*;
#(
  parameter logic [CRC_W-1:0] ALT_POLY = 16'h8BB7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              lsbFirst,
  input  polySel_e          polySel,
  output logic              txBit,
  output logic [CRC_W-1:0]  crcValue
);
  localparam int NBYTES = CRC_W / BYTE_W;

  logic [CRC_W-1:0]  shiftReg;
  logic [CRC_W-1:0]  crcReg;
  logic [CRC_W-1:0]  crcNext;
  logic [CRC_W-1:0]  crcOrdered;
  logic [CRC_W-1:0]  poly;
  logic [BYTE_W-1:0] byteOrdered;

  assign poly     = polyFor(polySel, ALT_POLY);
  assign txBit    = shiftReg[CRC_W-1];
  assign crcValue = crcReg;

  // the shifter always emits its top bit, so LSB-first order is a byte mirror
  always_comb begin
    for (int i = 0; i < BYTE_W; i++)
      byteOrdered[i] = lsbFirst ? byteData[BYTE_W-1-i] : byteData[i];
  end

  generate
    for (genvar k = 0; k < NBYTES; k++) begin : g_crcByte
      for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
        assign crcOrdered[k*BYTE_W+j] =
          lsbFirst ? crcReg[k*BYTE_W+BYTE_W-1-j] : crcReg[k*BYTE_W+j];
      end
    end
  endgenerate

  always_comb begin
    crcNext = {crcReg[CRC_W-2:0], 1'b0};
    if (crcReg[CRC_W-1] ^ txBit) crcNext = crcNext ^ poly;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      crcReg   <= '1;
    end else begin
      if (strobes.preset)      crcReg <= '1;
      else if (strobes.update) crcReg <= crcNext;

      if (strobes.loadByte)
        shiftReg <= {byteOrdered, {(CRC_W-BYTE_W){1'b0}}};
      else if (strobes.loadCrc)
        shiftReg <= crcOrdered;
      else if (strobes.shift)
        shiftReg <= {shiftReg[CRC_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/pkt_crc_gen.sv
module pkt_crc_gen
  import pkt_crc_pkg::*;
#(
  parameter logic [CRC_W-1:0] ALT_POLY  = 16'h8BB7,
  parameter logic [CFG_W-1:0] RESET_CFG = 8'b1000_1101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              sopPulse,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              byteIsData,
  input  logic              lastByte,
  output logic              byteReady,
  output logic              txValid,
  output logic              txBit,
  output logic              txIsCrc,
  output logic              txLast,
  output logic [CRC_W-1:0]  crcValue
);
  dpStrobes_t strobes;
  cfgFields_t actCfg;
  logic       busy;

  pkt_crc_ctrl #(.RESET_CFG(RESET_CFG)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .sopPulse(sopPulse), .byteValid(byteValid), .byteIsData(byteIsData),
    .lastByte(lastByte), .byteReady(byteReady), .strobes(strobes),
    .actCfg(actCfg), .txValid(txValid), .txIsCrc(txIsCrc),
    .txLast(txLast), .busy(busy)
  );

  pkt_crc_dp #(.ALT_POLY(ALT_POLY)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteData(byteData),
    .lsbFirst(actCfg.lsbFirst), .polySel(actCfg.polySel),
    .txBit(txBit), .crcValue(crcValue)
  );
endmodule

// File: rtl/pkt_crc_chk.sv
module pkt_crc_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sopPulse,
  input logic        byteValid,
  input logic        byteReady,
  input logic        txValid,
  input logic        txIsCrc,
  input logic        txLast,
  input logic        busy,
  input logic [15:0] crcValue
);
  // R6
  crc_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIsCrc |-> txValid);

  // R6
  last_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid);

  // R10
  accept_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && byteReady |=> txValid && !byteReady);

  // R3
  preset_chk: assert property (@(posedge clk) disable iff (!rstN)
    sopPulse && !busy |=> (crcValue == 16'hFFFF) && byteReady);

  // R3
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txValid && !(sopPulse && !busy) |=> $stable(crcValue));

  // R9
  sop_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    sopPulse && busy && !txLast |=> busy);
endmodule

bind pkt_crc_gen pkt_crc_chk chk_i (
  .clk(clk), .rstN(rstN), .sopPulse(sopPulse), .byteValid(byteValid),
  .byteReady(byteReady), .txValid(txValid), .txIsCrc(txIsCrc),
  .txLast(txLast), .busy(busy), .crcValue(crcValue)
);

// File: tb/pkt_crc_gen_tb_top.sv
module pkt_crc_gen_tb_top;
  localparam logic [15:0] ALT = 16'h8BB7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, cfgWe, sopPulse, byteValid, byteIsData, lastByte;
  logic [7:0] cfgData, byteData;
  logic byteReady, txValid, txBit, txIsCrc, txLast;
  logic [15:0] crcValue;

  int checks = 0, fails = 0, cycles = 0;

  logic [7:0] pData [16];
  logic       pIsData [16];
  logic       capBits [512];
  logic       expBits [512];
  int capCnt, capCrcCnt, capLastIdx, expCnt;
  logic capEn = 1'b0;
  logic [15:0] expCrc;

  pkt_crc_gen #(.ALT_POLY(ALT)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .sopPulse(sopPulse), .byteValid(byteValid), .byteData(byteData),
    .byteIsData(byteIsData), .lastByte(lastByte), .byteReady(byteReady),
    .txValid(txValid), .txBit(txBit), .txIsCrc(txIsCrc), .txLast(txLast),
    .crcValue(crcValue)
  );

  always @(negedge clk) begin
    if (capEn && txValid) begin
      if (capCnt < 512) capBits[capCnt] = txBit;
      if (txIsCrc) capCrcCnt++;
      if (txLast) capLastIdx = capCnt;
      capCnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] polyOf(input logic [1:0] sel);
    case (sel)
      2'b00: return 16'h1021;
      2'b01: return 16'h8005;
      2'b10: return 16'h3D65;
      default: return ALT;
    endcase
  endfunction

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic b,
                                          input logic [15:0] p);
    logic fb = c[15] ^ b;
    return fb ? ({c[14:0], 1'b0} ^ p) : {c[14:0], 1'b0};
  endfunction

  task automatic buildExp(input logic [7:0] cfg, input int n);
    logic lsb = cfg[6], donly = cfg[5], on = cfg[3] && cfg[2];
    logic [15:0] p = polyOf(cfg[1:0]);
    logic [15:0] c = 16'hFFFF;
    logic [7:0] cb;
    expCnt = 0;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic b = lsb ? pData[i][j] : pData[i][7-j];
        expBits[expCnt++] = b;
        if (on && (!donly || pIsData[i])) c = crcStep(c, b, p);
      end
    end
    expCrc = c;
    if (on) begin
      for (int h = 0; h < 2; h++) begin
        cb = (h == 0) ? c[15:8] : c[7:0];
        for (int j = 0; j < 8; j++) expBits[expCnt++] = lsb ? cb[j] : cb[7-j];
      end
    end
  endtask

  task automatic sendPacket(input logic [7:0] cfg, input bit doWrite, input int n,
                            input bit midAct, input logic [7:0] midCfg,
                            input string tag);
    int guard, mism;
    bit on = cfg[3] && cfg[2];
    @(negedge clk);
    if (doWrite) begin
      cfgWe = 1'b1; cfgData = cfg;
      @(negedge clk);
      cfgWe = 1'b0;
    end
    capCnt = 0; capCrcCnt = 0; capLastIdx = -1; capEn = 1'b1;
    sopPulse = 1'b1;
    @(negedge clk);
    sopPulse = 1'b0;
    for (int i = 0; i < n; i++) begin
      guard = 0;
      while (!byteReady && guard < 100) begin @(negedge clk); guard++; end
      byteValid = 1'b1; byteData = pData[i]; byteIsData = pIsData[i];
      lastByte = (i == n - 1);
      @(negedge clk);
      byteValid = 1'b0; lastByte = 1'b0;
      // R10: first bit one cycle after the accepting edge
      chk(txValid && !byteReady, "R10", "bit after accept {txValid,byteReady}",
          {txValid, byteReady}, 2);
      if (midAct && i == 0) begin
        cfgWe = 1'b1; cfgData = midCfg; sopPulse = 1'b1;
        @(negedge clk);
        cfgWe = 1'b0; sopPulse = 1'b0;
      end
    end
    guard = 0;
    while (capLastIdx < 0 && guard < 100) begin @(negedge clk); #1; guard++; end
    @(negedge clk);
    @(negedge clk);
    capEn = 1'b0;
    buildExp(cfg, n);
    chk(capCnt == expCnt, tag, "bit count", capCnt, expCnt);
    mism = 0;
    for (int i = 0; i < expCnt && i < capCnt; i++)
      if (capBits[i] !== expBits[i]) mism++;
    chk(mism == 0, tag, "mismatched bits", mism, 0);
    chk(crcValue == expCrc, tag, "crcValue", crcValue, expCrc);
    chk(capCrcCnt == (on ? 16 : 0), tag, "crc bit count", capCrcCnt, on ? 16 : 0);
    chk(capLastIdx == expCnt - 1, tag, "txLast index", capLastIdx, expCnt - 1);
  endtask

  task automatic fillAscii;
    for (int i = 0; i < 9; i++) begin
      pData[i] = 8'h31 + 8'(i);
      pIsData[i] = 1'b1;
    end
  endtask

  task automatic fillRandom(input int n, input int hdr);
    for (int i = 0; i < n; i++) begin
      pData[i] = 8'($urandom);
      pIsData[i] = (i >= hdr);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rstN = 1'b0; cfgWe = 1'b0; cfgData = '0; sopPulse = 1'b0;
    byteValid = 1'b0; byteData = '0; byteIsData = 1'b0; lastByte = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R3 reset state
    chk(!byteReady && !txValid, "R1", "idle outputs after reset",
        {byteReady, txValid}, 0);
    chk(crcValue == 16'hFFFF, "R3", "crcValue after reset", crcValue, 16'hFFFF);

    // R1: default register, no write
    fillRandom(6, 2);
    sendPacket(8'h8D, 1'b0, 6, 1'b0, 8'h00, "R1");

    // R2: known answers
    fillAscii();
    sendPacket(8'h0C, 1'b1, 9, 1'b0, 8'h00, "R2");
    chk(crcValue == 16'h29B1, "R2", "code 00 check value", crcValue, 16'h29B1);
    sendPacket(8'h0D, 1'b1, 9, 1'b0, 8'h00, "R2");
    chk(crcValue == 16'hAEE7, "R2", "code 01 check value", crcValue, 16'hAEE7);
    fillRandom(7, 0);
    sendPacket(8'h0E, 1'b1, 7, 1'b0, 8'h00, "R2");
    sendPacket(8'h0F, 1'b1, 7, 1'b0, 8'h00, "R2");

    // R1: bits 7 and 4 have no effect
    sendPacket(8'h1D, 1'b1, 7, 1'b0, 8'h00, "R1");

    // R5: LSB-first, including CRC bytes
    sendPacket(8'h4C, 1'b1, 7, 1'b0, 8'h00, "R5");

    // R4: payload-only coverage
    fillRandom(8, 3);
    sendPacket(8'h2D, 1'b1, 8, 1'b0, 8'h00, "R4");
    sendPacket(8'h6E, 1'b1, 8, 1'b0, 8'h00, "R4");

    // R7: CRC off, packet handling off
    sendPacket(8'h09, 1'b1, 5, 1'b0, 8'h00, "R7");
    chk(crcValue == 16'hFFFF, "R7", "crcValue untouched", crcValue, 16'hFFFF);
    sendPacket(8'h05, 1'b1, 5, 1'b0, 8'h00, "R7");

    // R6: single-byte packet with CRC
    fillRandom(1, 0);
    sendPacket(8'h0D, 1'b1, 1, 1'b0, 8'h00, "R6");

    // R8 R9: mid-packet write and start pulse, then next packet uses new value
    fillRandom(5, 1);
    sendPacket(8'h0D, 1'b1, 5, 1'b1, 8'h6E, "R8 R9");
    fillRandom(5, 2);
    sendPacket(8'h6E, 1'b0, 5, 1'b0, 8'h00, "R8");

    // R3: random configurations and packets
    for (int k = 0; k < 30; k++) begin
      int n = 1 + int'($urandom % 12);
      int hdr = int'($urandom % n);
      logic [7:0] cfg = 8'($urandom);
      fillRandom(n, hdr);
      sendPacket(cfg, 1'b1, n, 1'b0, 8'h00, "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule